// File: doc/BRIEF.md
# Zeroization Engine Control Register Bank

This block is the register bank through which a management processor launches and supervises a set of state-clearing engines, one per chip domain. Software writes a bit mask to a start register, and each selected engine receives a one-cycle start pulse. Each engine returns a completion level and a pass/fail level. The completion level idles high, drops while the engine works, and returns high when it is done. The bank shows both levels to software and raises an interrupt when any engine finishes.

A hardware request vector can also start engines, but only while a scan-enable bit in the safety-gate register is set. A software error log records clearing failures. It accepts writes only while a log-enable bit in the same safety-gate register is set. Only power-on reset clears the error log; the ordinary system reset leaves it unchanged.

The engines occupy sparse bit positions: 0 to 3, 6, 7, 10, 12, 13, 16 and 17 (mask 0x000334CF).

Top module: `zclr_ctrl`

## Requirements
- R1: A write to word offset 0 (start) gives a start pulse on `eng_start` for every implemented bit that is set in the write data. The pulse appears on the clock edge that samples the write and lasts exactly one cycle. A read of offset 0 always returns 0.
- R2: Bits outside mask 0x000334CF never pulse `eng_start`, never set the interrupt, and always read as 0 at offsets 1 and 2.
- R3: A read of offset 1 (done) returns `eng_done` masked to the implemented bits.
- R4: A read of offset 2 (result) returns `eng_pass` masked to the implemented bits.
- R5: `hw_req` is ORed into `eng_start` one cycle later, and only while bit 0 of offset 3 (safety gate, reset 0) is set. Otherwise it is blocked.
- R6: A 0-to-1 change on an implemented `eng_done` bit sets interrupt status (offset 5, bit 0) on the third rising clock edge after the change. A 1-to-0 change never sets it.
- R7: Writing 1 to bit 0 of offset 5 clears the interrupt status, and writing 0 leaves it unchanged. If a new completion arrives on the same edge as the clear, the status stays set.
- R8: `irq` is high exactly when the interrupt status is set and bit 0 of offset 6 (interrupt enable, reset 0) is set.
- R9: A write to offset 4 (error log) takes effect only while bit 1 of offset 3 is set. Otherwise the log keeps its value.
- R10: The error log keeps its value through `rst_n`. Only `por_n` clears it to 0. Every other register is cleared by either reset.
- R11: `rdata` is loaded on the edge that samples `rd_en` and holds its value otherwise. Offsets 7 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hw_req | input | 32 | Hardware start request, one bit per engine |
| eng_start | output | 32 | One-cycle start pulse, one bit per engine |
| eng_done | input | 32 | Engine completion level, high when idle |
| eng_pass | input | 32 | Engine pass/fail level |
| irq | output | 1 | Completion interrupt |

## Verification
Start pulses and read data appear on the first rising edge after the request, so the bench checks them on the following falling edge. The interrupt status takes three edges from a completion change: two synchronizer stages and then the status flop. The bench therefore counts falling edges from the moment it changes `eng_done`. It confirms that `irq` is still low after two edges and high after the third. The set-versus-clear race is arranged so that the clear write lands on that third edge. Hold behaviour is checked on the cycle after each stimulus, before anything else is driven.

// File: rtl/zclr_pkg.sv
// Package: shared constants for the zeroization control bank.
// Assumes word-addressed register offsets and one bit per engine.
package zclr_pkg;
    localparam int          ZC_DATA_W    = 32;
    localparam int          ZC_ADDR_W    = 4;
    localparam logic [31:0] ZC_ENG_MASK  = 32'h0003_34CF;
    localparam int          ZC_SYNC_STG  = 2;

    localparam int OFS_START  = 0;
    localparam int OFS_DONE   = 1;
    localparam int OFS_RESULT = 2;
    localparam int OFS_GATE   = 3;
    localparam int OFS_ERRLOG = 4;
    localparam int OFS_IRQST  = 5;
    localparam int OFS_IRQEN  = 6;

    localparam int GATE_HW_BIT  = 0;
    localparam int GATE_LOG_BIT = 1;
endpackage

// File: rtl/zclr_done_sync.sv
// Module: zclr_done_sync
// Synchronizes the engine completion levels into the register clock and
// flags 0-to-1 changes. Assumes idle completion level is high, so all
// stages reset to 1 to avoid a false edge after reset.
module zclr_done_sync #(
    parameter int          W      = 32,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] MASK  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture flop of the synchronizer.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= '1;
                    else        stg[g] <= din;
                end
            end else begin : g_next
                // Purpose: further synchronizer stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= '1;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    // Purpose: remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= stg[LAST];
    end

    assign rise = stg[LAST] & ~prev_q & MASK;
endmodule

// File: rtl/zclr_trig.sv
// Module: zclr_trig
// Merges software and gated hardware start requests into registered
// one-cycle start pulses. Assumes hardware requests arrive as pulses.
module zclr_trig #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_fire,
    input  logic [W-1:0] sw_bits,
    input  logic [W-1:0] hw_req,
    input  logic         hw_allow,
    output logic [W-1:0] start
);
    logic [W-1:0] sw_sel;
    logic [W-1:0] hw_sel;

    // Purpose: select the request sources active this cycle.
    always_comb begin
        sw_sel = sw_fire  ? sw_bits : '0;
        hw_sel = hw_allow ? hw_req  : '0;
    end

    // Purpose: register the merged, masked start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) start <= '0;
        else        start <= (sw_sel | hw_sel) & MASK;
    end
endmodule

// File: rtl/zclr_regs.sv
// Module: zclr_regs
// Holds the safety gate, error log, interrupt status and enable, and the
// registered read port. Assumes rst_n already includes power-on reset;
// the error log alone uses por_n.
module zclr_regs #(
    parameter int           DW   = 32,
    parameter int           AW   = 4,
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] done_raw,
    input  logic [DW-1:0] pass_raw,
    input  logic          rise_any,
    output logic [DW-1:0] rdata,
    output logic          gate_scan,
    output logic          gate_log,
    output logic          irq_en,
    output logic          irq,
    output logic [DW-1:0] errlog_q
);
    import zclr_pkg::*;

    logic          irq_st;
    logic [DW-1:0] rd_mux;
    logic          wr_gate, wr_err, wr_ist, wr_ien;

    // Purpose: decode write strobes per register.
    always_comb begin
        wr_gate = wr_en && (addr == AW'(OFS_GATE));
        wr_err  = wr_en && (addr == AW'(OFS_ERRLOG));
        wr_ist  = wr_en && (addr == AW'(OFS_IRQST));
        wr_ien  = wr_en && (addr == AW'(OFS_IRQEN));
    end

    // Purpose: safety gate bits and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_scan <= 1'b0;
            gate_log  <= 1'b0;
            irq_en    <= 1'b0;
        end else begin
            if (wr_gate) begin
                gate_scan <= wdata[GATE_HW_BIT];
                gate_log  <= wdata[GATE_LOG_BIT];
            end
            if (wr_ien) irq_en <= wdata[0];
        end
    end

    // Purpose: sticky interrupt status, new completion beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq_st <= 1'b0;
        else if (rise_any)            irq_st <= 1'b1;
        else if (wr_ist && wdata[0])  irq_st <= 1'b0;
    end

    // Purpose: write-protected error log, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n)                         errlog_q <= '0;
        else if (rst_n && wr_err && gate_log) errlog_q <= wdata;
    end

    // Purpose: read multiplexer over the register offsets.
    always_comb begin
        rd_mux = '0;
        case (addr)
            AW'(OFS_DONE):   rd_mux = done_raw & MASK;
            AW'(OFS_RESULT): rd_mux = pass_raw & MASK;
            AW'(OFS_GATE): begin
                rd_mux[GATE_HW_BIT]  = gate_scan;
                rd_mux[GATE_LOG_BIT] = gate_log;
            end
            AW'(OFS_ERRLOG): rd_mux = errlog_q;
            AW'(OFS_IRQST):  rd_mux[0] = irq_st;
            AW'(OFS_IRQEN):  rd_mux[0] = irq_en;
            default:         rd_mux = '0;
        endcase
    end

    // Purpose: registered read data, held while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = irq_st & irq_en;
endmodule

// File: rtl/zclr_ctrl.sv
// Module: zclr_ctrl (top)
// Register bank that starts per-domain clearing engines and reports their
// completion and result. Assumes engines pulse-start and hold done high
// when idle; sync reset rst_n, power-on reset por_n (both active-low).
module zclr_ctrl #(
    parameter int                  DATA_W   = zclr_pkg::ZC_DATA_W,
    parameter int                  ADDR_W   = zclr_pkg::ZC_ADDR_W,
    parameter logic [DATA_W-1:0]   ENG_MASK = zclr_pkg::ZC_ENG_MASK,
    parameter int                  SYNC_STG = zclr_pkg::ZC_SYNC_STG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] hw_req,
    output logic [DATA_W-1:0] eng_start,
    input  logic [DATA_W-1:0] eng_done,
    input  logic [DATA_W-1:0] eng_pass,
    output logic              irq
);
    import zclr_pkg::*;

    logic              sys_rst_n;
    logic              sw_fire;
    logic [DATA_W-1:0] rise;
    logic              gate_scan, gate_log, irq_en;
    logic [DATA_W-1:0] errlog_q;

    assign sys_rst_n = rst_n & por_n;
    assign sw_fire   = wr_en && (addr == ADDR_W'(OFS_START));

    zclr_done_sync #(.W(DATA_W), .STAGES(SYNC_STG), .MASK(ENG_MASK)) u_sync (
        .clk(clk), .rst_n(sys_rst_n), .din(eng_done), .rise(rise)
    );

    zclr_trig #(.W(DATA_W), .MASK(ENG_MASK)) u_trig (
        .clk(clk), .rst_n(sys_rst_n), .sw_fire(sw_fire), .sw_bits(wdata),
        .hw_req(hw_req), .hw_allow(gate_scan), .start(eng_start)
    );

    zclr_regs #(.DW(DATA_W), .AW(ADDR_W), .MASK(ENG_MASK)) u_regs (
        .clk(clk), .rst_n(sys_rst_n), .por_n(por_n), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .done_raw(eng_done),
        .pass_raw(eng_pass), .rise_any(|rise), .rdata(rdata),
        .gate_scan(gate_scan), .gate_log(gate_log), .irq_en(irq_en),
        .irq(irq), .errlog_q(errlog_q)
    );
endmodule

// File: rtl/zclr_ctrl_chk.sv
// Module: zclr_ctrl_chk
// Property checker bound to zclr_ctrl; observes ports and gate/log state.
module zclr_ctrl_chk #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 4,
    parameter logic [DATA_W-1:0] ENG_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] hw_req,
    input logic [DATA_W-1:0] eng_start,
    input logic [DATA_W-1:0] eng_done,
    input logic              irq,
    input logic              gate_scan,
    input logic              gate_log,
    input logic              irq_en,
    input logic [DATA_W-1:0] errlog_q
);
    import zclr_pkg::*;

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && addr == ADDR_W'(OFS_START)) |=>
        ((eng_start & $past(wdata) & ENG_MASK) == ($past(wdata) & ENG_MASK)));

    assert_start_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_en && addr == ADDR_W'(OFS_START)) |=> (rdata == '0));

    assert_start_legal_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ((eng_start & ~ENG_MASK) == '0));

    assert_done_read_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_en && addr == ADDR_W'(OFS_DONE)) |=> (rdata == ($past(eng_done) & ENG_MASK)));

    assert_hw_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!gate_scan && !(wr_en && addr == ADDR_W'(OFS_START))) |=> (eng_start == '0));

    assert_irq_enable_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        irq |-> irq_en);

    assert_log_protect_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && addr == ADDR_W'(OFS_ERRLOG) && !gate_log) |=> $stable(errlog_q));

    assert_log_keep_R10: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> $stable(errlog_q));

    // hw_req is observed only through the gated start path above.
    logic unused_ok;
    assign unused_ok = ^hw_req;
endmodule

bind zclr_ctrl zclr_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENG_MASK(ENG_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hw_req(hw_req),
    .eng_start(eng_start), .eng_done(eng_done), .irq(irq),
    .gate_scan(gate_scan), .gate_log(gate_log), .irq_en(irq_en),
    .errlog_q(errlog_q)
);

// File: tb/zclr_ctrl_bench.sv
// Bench for zclr_ctrl: vector table for start decoding, then directed tests.
module zclr_ctrl_bench;
    localparam logic [31:0] MASK = 32'h0003_34CF;

    // {write data, expected start pulse}
    localparam logic [63:0] VEC [0:5] = '{
        {32'h0000_0001, 32'h0000_0001},
        {32'hFFFF_FFFF, 32'h0003_34CF},
        {32'h0000_0030, 32'h0000_0000},
        {32'h0000_3C00, 32'h0000_3400},
        {32'h000C_0000, 32'h0000_0000},
        {32'h0003_00C0, 32'h0003_00C0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, hw_req = '0, eng_start, eng_done, eng_pass = '0;
    logic        irq;
    logic        model_en = 1'b1;
    logic [31:0] man_done = '1, model_done;
    logic [3:0]  cnt [32];
    int          total = 0, fails = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    assign eng_done = model_en ? model_done : man_done;

    // Engine model: done drops on a start pulse and returns after a delay.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_done <= '1;
            for (int b = 0; b < 32; b++) cnt[b] <= '0;
        end else begin
            for (int b = 0; b < 32; b++) begin
                if (eng_start[b]) begin
                    model_done[b] <= 1'b0;
                    cnt[b] <= 4'd8;
                end else if (cnt[b] == 4'd1) begin
                    model_done[b] <= 1'b1;
                    cnt[b] <= 4'd0;
                end else if (cnt[b] != 4'd0) begin
                    cnt[b] <= cnt[b] - 4'd1;
                end
            end
        end
    end

    zclr_ctrl u_zclr_ctrl (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .hw_req(hw_req),
        .eng_start(eng_start), .eng_done(eng_done), .eng_pass(eng_pass), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write; returns at the falling edge after the sampling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        // Reset state (R10, R8, R1)
        chk("R1 reset start", eng_start, 32'h0);
        chk("R8 reset irq", {31'h0, irq}, 32'h0);
        rd(4'd3, rv); chk("R10 reset gate", rv, 32'h0);
        rd(4'd4, rv); chk("R10 por errlog", rv, 32'h0);
        rd(4'd1, rv); chk("R3 idle done", rv, MASK);
        rd(4'd0, rv); chk("R1 start reads zero", rv, 32'h0);

        // Vector table: start decoding (R1, R2)
        for (int i = 0; i < 6; i++) begin
            wr(4'd0, VEC[i][63:32]);
            chk("R1/R2 start pulse", eng_start, VEC[i][31:0]);
            @(negedge clk);
            chk("R1 pulse one cycle", eng_start, 32'h0);
        end
        repeat (30) @(negedge clk);

        // R3: done drops while engine 16 runs, then returns
        wr(4'd0, 32'h0001_0000);
        rd(4'd1, rv); chk("R3 done low while running", rv, MASK & ~32'h0001_0000);
        repeat (20) @(negedge clk);
        rd(4'd1, rv); chk("R3 done back high", rv, MASK);
        rd(4'd5, rv); chk("R6 status set by completion", rv, 32'h1);

        // R4: result register
        eng_pass = '1;
        rd(4'd2, rv); chk("R4 result all", rv, MASK);
        eng_pass = 32'h0011_0025;
        rd(4'd2, rv); chk("R4 result pattern", rv, 32'h0001_0005);

        // R7: clear behaviour
        wr(4'd5, 32'h0);
        rd(4'd5, rv); chk("R7 write zero keeps", rv, 32'h1);
        wr(4'd5, 32'h1);
        rd(4'd5, rv); chk("R7 write one clears", rv, 32'h0);

        // R6 precise timing with manual done
        man_done = '1; model_en = 1'b0;
        wr(4'd6, 32'h1);
        @(negedge clk); man_done[6] = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'd5, rv); chk("R6 falling edge ignored", rv, 32'h0);
        man_done[6] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 not yet after two edges", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 set on third edge", {31'h0, irq}, 32'h1);

        // R8: enable gating of irq
        wr(4'd6, 32'h0);
        chk("R8 masked irq", {31'h0, irq}, 32'h0);
        wr(4'd6, 32'h1);
        chk("R8 enabled irq", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h1);

        // R2: unimplemented bit 5 never interrupts
        @(negedge clk); man_done[5] = 1'b0;
        repeat (4) @(negedge clk); man_done[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 unimplemented done no irq", {31'h0, irq}, 32'h0);
        rd(4'd1, rv); chk("R2 done reads masked", rv & 32'h20, 32'h0);

        // R7: set wins over simultaneous clear
        @(negedge clk); man_done[7] = 1'b0;
        repeat (4) @(negedge clk);
        man_done[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd5; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk("R7 set beats clear", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h1);

        // R5: hardware request gating
        @(negedge clk); hw_req = 32'h2;
        @(negedge clk); hw_req = 32'h0;
        chk("R5 hw blocked", eng_start, 32'h0);
        wr(4'd3, 32'h1);
        @(negedge clk); hw_req = 32'h0000_0012;
        @(negedge clk); hw_req = 32'h0;
        chk("R5 hw passes masked", eng_start, 32'h2);

        // R9: write protection of error log
        wr(4'd4, 32'hA5A5_0001);
        rd(4'd4, rv); chk("R9 protected write ignored", rv, 32'h0);
        wr(4'd3, 32'h2);
        wr(4'd4, 32'hA5A5_0001);
        rd(4'd4, rv); chk("R9 enabled write lands", rv, 32'hA5A5_0001);

        // R11: hold and unmapped offsets
        wr(4'd3, 32'h3);
        chk("R11 rdata held", rdata, 32'hA5A5_0001);
        rd(4'd7, rv); chk("R11 unmapped 7", rv, 32'h0);
        rd(4'd15, rv); chk("R11 unmapped 15", rv, 32'h0);

        // R10: system reset keeps log, power-on reset clears it
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        rd(4'd4, rv); chk("R10 log survives rst_n", rv, 32'hA5A5_0001);
        rd(4'd3, rv); chk("R10 gate cleared by rst_n", rv, 32'h0);
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk); por_n = 1'b1;
        rd(4'd4, rv); chk("R10 log cleared by por_n", rv, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule